// File: doc/BRIEF.md
# Reset and Boot-Remap Controller

This block turns an external active-low reset pin and a watchdog reset request into one system reset for the rest of the chip. The system reset is applied asynchronously and released through a short synchronizer chain. A free-running counter then holds back the processor's first instruction fetch for a fixed number of clocks, so that clocks, memories and configuration can settle before the core starts to run.

Two configuration straps are captured while the external reset is held: the boot-memory select and the active-low tri-state select. A strap is accepted only when it has kept one level for the whole capture window. A watchdog reset never captures the straps again. The block also holds a one-way remap flag that software sets. Only a reset clears it. The flag and the latched boot strap together choose which memory answers at address zero.

Top module: `reset_boot_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_no` is low at once, without waiting for a clock edge. After `rst_ni` rises, `sys_rst_no` goes high after the second rising clock edge that sees `rst_ni` high.
- R2: A clock edge with `wdt_rst_i` high drives `sys_rst_no` low after that edge. It is released after the second edge with `wdt_rst_i` low. When both resets are active, the external reset governs: the straps are still captured at its release, and the system stays in reset until the watchdog request also drops.
- R3: `fetch_en_o` is low during any reset. It goes high after the 80th rising edge that follows the last reset cause (`rst_ni` low or `wdt_rst_i` high), and it stays high until the next reset.
- R4: Strap samples are taken on every clock edge of the external reset hold, which includes the first edge with `rst_ni` high. At the following edge, `boot_mode_o` takes the value of `boot_mode_i` if the last 10 samples were all equal. The value 1 means boot from internal SRAM; 0 means boot from external memory on chip select 0.
- R5: If the last 10 samples of a strap are not all equal, or if fewer than 10 were taken, the strap output keeps its previous value.
- R6: `tristate_o` is 1 (all output drivers disabled) when `tri_sel_ni` was captured low under the rule of R4, and 0 when it was captured high.
- R7: A watchdog reset does not change `boot_mode_o` or `tristate_o`, whatever the strap inputs do.
- R8: A write (`remap_wr_i` high) with `remap_wdata_i` 1 sets `remap_o` after that edge, but only when `sys_rst_no` was high before the edge. A write of 0 has no effect. Writes made while the system reset is active are ignored.
- R9: Once set, `remap_o` stays high until `rst_ni` goes low or `wdt_rst_i` is seen high at a clock edge.
- R10: `zero_sel_o` gives the memory at address zero: 2 means primary internal SRAM (when `remap_o` is 1); otherwise 1 means internal boot SRAM (when `boot_mode_o` is 1), and 0 means external memory on chip select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | External reset, active low, asynchronous assertion |
| wdt_rst_i | input | 1 | Watchdog reset request, active high, synchronous |
| boot_mode_i | input | 1 | Boot-memory strap |
| tri_sel_ni | input | 1 | Tri-state strap, active low |
| remap_wr_i | input | 1 | Remap control write strobe |
| remap_wdata_i | input | 1 | Remap control write data |
| sys_rst_no | output | 1 | Synchronized system reset, active low |
| fetch_en_o | output | 1 | First-fetch release |
| boot_mode_o | output | 1 | Latched boot-memory strap |
| tristate_o | output | 1 | Tri-state mode active |
| remap_o | output | 1 | Remap flag |
| zero_sel_o | output | 2 | Address-zero memory select |

## Verification
The assertions check, on every cycle, the rules that hold at all times. A watchdog request forces the system reset. The fetch release never shows while the system is in reset, and once high it stays high until a reset. The remap flag only moves in its permitted direction, and it cannot be set while the system is in reset. The strap outputs stay still after external release, and so through any watchdog reset. The exact release timing of the reset and of the fetch enable, the capture window of 10 samples, and the handling of straps that change or of a reset that is too short can only be shown by the bench scenarios. The same holds for overlapping external and watchdog resets. The bench checks all of these against a behavioural model every cycle.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [1:0] {
    ZSEL_EXT_CS0   = 2'd0,
    ZSEL_BOOT_SRAM = 2'd1,
    ZSEL_PRIM_SRAM = 2'd2
  } zero_sel_e;

  localparam int STRAP_NUM  = 2;
  localparam int STRAP_BOOT = 0;
  localparam int STRAP_TRI  = 1;
endpackage

// File: rtl/rbc_rst_sync.sv
module rbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_rst_i,
  output logic sys_rst_no,
  output logic ext_rel_o
);
  logic [STAGES-1:0] sync_q;
  logic              ext_rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sync_q <= '0;
    else if (wdt_rst_i) sync_q <= '0;
    else                sync_q <= STAGES'({sync_q, 1'b1});
  end

  // external-only release marker, not touched by the watchdog
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_rel_q <= 1'b0;
    else         ext_rel_q <= 1'b1;
  end

  assign sys_rst_no = sync_q[STAGES-1];
  assign ext_rel_o  = ext_rel_q;

  p_wdt_forces_rst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_i |=> !sys_rst_no);
endmodule

// File: rtl/rbc_strap_sampler.sv
module rbc_strap_sampler #(
  parameter int WIN = 10
) (
  input  logic clk_i,
  input  logic hold_i,
  input  logic strap_i,
  output logic strap_o
);
  localparam int CW = $clog2(WIN + 1);

  logic          prev_hold_q;
  logic          last_q;
  logic          strap_q;
  logic [CW-1:0] run_q;

  // runs through reset on purpose: no reset on these flops
  always_ff @(posedge clk_i) begin
    prev_hold_q <= hold_i;
    if (hold_i) begin
      last_q <= strap_i;
      if (prev_hold_q && (strap_i == last_q)) begin
        if (run_q != CW'(WIN)) run_q <= run_q + 1'b1;
      end else begin
        run_q <= CW'(1);
      end
    end else if (prev_hold_q && (run_q == CW'(WIN))) begin
      strap_q <= last_q;
    end
  end

  assign strap_o = strap_q;
endmodule

// File: rtl/rbc_fetch_delay.sv
module rbc_fetch_delay #(
  parameter int DELAY = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_rst_i,
  output logic fetch_en_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (wdt_rst_i)           cnt_q <= '0;
    else if (cnt_q != CW'(DELAY)) cnt_q <= cnt_q + 1'b1;
  end

  assign fetch_en_o = (cnt_q == CW'(DELAY));

  p_fetch_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o && !wdt_rst_i |=> fetch_en_o);
endmodule

// File: rtl/reset_boot_ctrl.sv
module reset_boot_ctrl
  import rbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_WIN   = 10,
  parameter int FETCH_DLY   = 80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wdt_rst_i,
  input  logic       boot_mode_i,
  input  logic       tri_sel_ni,
  input  logic       remap_wr_i,
  input  logic       remap_wdata_i,
  output logic       sys_rst_no,
  output logic       fetch_en_o,
  output logic       boot_mode_o,
  output logic       tristate_o,
  output logic       remap_o,
  output logic [1:0] zero_sel_o
);
  logic                 ext_rel;
  logic [STRAP_NUM-1:0] strap_in;
  logic [STRAP_NUM-1:0] strap_q;
  logic                 remap_q;
  zero_sel_e            zsel;

  rbc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdt_rst_i  (wdt_rst_i),
    .sys_rst_no (sys_rst_no),
    .ext_rel_o  (ext_rel)
  );

  assign strap_in[STRAP_BOOT] = boot_mode_i;
  assign strap_in[STRAP_TRI]  = tri_sel_ni;

  for (genvar g = 0; g < STRAP_NUM; g++) begin : g_strap
    rbc_strap_sampler #(.WIN(STRAP_WIN)) u_samp (
      .clk_i   (clk_i),
      .hold_i  (!ext_rel),
      .strap_i (strap_in[g]),
      .strap_o (strap_q[g])
    );
  end

  assign boot_mode_o = strap_q[STRAP_BOOT];
  assign tristate_o  = !strap_q[STRAP_TRI];

  rbc_fetch_delay #(.DELAY(FETCH_DLY)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdt_rst_i  (wdt_rst_i),
    .fetch_en_o (fetch_en_o)
  );

  // one-way: only a reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           remap_q <= 1'b0;
    else if (wdt_rst_i)                                    remap_q <= 1'b0;
    else if (sys_rst_no && remap_wr_i && remap_wdata_i)    remap_q <= 1'b1;
  end

  assign remap_o = remap_q;

  always_comb begin
    if (remap_q)          zsel = ZSEL_PRIM_SRAM;
    else if (boot_mode_o) zsel = ZSEL_BOOT_SRAM;
    else                  zsel = ZSEL_EXT_CS0;
  end
  assign zero_sel_o = zsel;

  p_fetch_after_sys_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |-> !fetch_en_o);
  p_remap_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_o && !wdt_rst_i |=> remap_o);
  p_remap_set_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !remap_o && !(remap_wr_i && remap_wdata_i) |=> !remap_o);
  p_remap_not_in_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |=> !remap_o);
  p_strap_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rel && $past(ext_rel) |=> $stable(boot_mode_o) && $stable(tristate_o));
endmodule

// File: tb/reset_boot_ctrl_bench.sv
`timescale 1ns/1ps
module reset_boot_ctrl_bench;
  localparam int WIN = 10;
  localparam int DLY = 80;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, wdt_rst_i = 1'b0, boot_mode_i = 1'b1, tri_sel_ni = 1'b1;
  logic remap_wr_i = 1'b0, remap_wdata_i = 1'b0;
  logic sys_rst_no, fetch_en_o, boot_mode_o, tristate_o, remap_o;
  logic [1:0] zero_sel_o;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  reset_boot_ctrl u_reset_boot_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wdt_rst_i(wdt_rst_i),
    .boot_mode_i(boot_mode_i), .tri_sel_ni(tri_sel_ni),
    .remap_wr_i(remap_wr_i), .remap_wdata_i(remap_wdata_i),
    .sys_rst_no(sys_rst_no), .fetch_en_o(fetch_en_o),
    .boot_mode_o(boot_mode_o), .tristate_o(tristate_o),
    .remap_o(remap_o), .zero_sel_o(zero_sel_o)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // behavioural reference model
  int  m_cnt = 0;
  bit  m_remap = 0, m_seen = 0, m_samp = 0;
  bit  m_boot, m_trin, m_boot_v = 0, m_tri_v = 0;
  bit  qb[$], qt[$];

  function automatic bit uniform(bit q[$]);
    if (q.size() < WIN) return 1'b0;
    foreach (q[i]) if (q[i] != q[0]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!m_seen) begin
      if (!m_samp) begin qb.delete(); qt.delete(); end
      qb.push_back(boot_mode_i); qt.push_back(tri_sel_ni);
      if (qb.size() > WIN) begin void'(qb.pop_front()); void'(qt.pop_front()); end
      m_samp = 1;
    end else if (m_samp) begin
      if (uniform(qb)) begin m_boot = qb[0]; m_boot_v = 1; end
      if (uniform(qt)) begin m_trin = qt[0]; m_tri_v = 1; end
      m_samp = 0;
    end
    m_seen = rst_ni;
    if (!rst_ni || wdt_rst_i) begin
      m_cnt = 0; m_remap = 0;
    end else begin
      if (m_cnt >= 2 && remap_wr_i && remap_wdata_i) m_remap = 1;
      if (m_cnt < 100000) m_cnt++;
    end
  end

  always @(negedge clk) begin
    #1;
    chk("R1", sys_rst_no, rst_ni && m_cnt >= 2);
    chk("R3", fetch_en_o, rst_ni && m_cnt >= DLY);
    chk("R8", remap_o, rst_ni && m_remap);
    if (m_boot_v) chk("R4", boot_mode_o, m_boot);
    if (m_tri_v)  chk("R6", tristate_o, !m_trin);
    if (m_boot_v) chk("R10", zero_sel_o, (rst_ni && m_remap) ? 2 : (m_boot ? 1 : 0));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // power-up reset, straps: SRAM boot, normal drivers
    cyc(12);
    rst_ni = 1'b1;
    cyc(1); chk("R1", sys_rst_no, 0);
    cyc(1); chk("R1", sys_rst_no, 1);
    chk("R4", boot_mode_o, 1); chk("R6", tristate_o, 0); chk("R10", zero_sel_o, 1);
    cyc(77); chk("R3", fetch_en_o, 0);
    cyc(1);  chk("R3", fetch_en_o, 1);
    cyc(4);
    // remap writes
    remap_wr_i = 1'b1; remap_wdata_i = 1'b0; cyc(1);
    remap_wr_i = 1'b0; chk("R8", remap_o, 0);
    remap_wr_i = 1'b1; remap_wdata_i = 1'b1; cyc(1);
    remap_wr_i = 1'b0; remap_wdata_i = 1'b0;
    chk("R8", remap_o, 1); chk("R10", zero_sel_o, 2);
    remap_wr_i = 1'b1; cyc(1); remap_wr_i = 1'b0;
    chk("R9", remap_o, 1);
    cyc(3);
    // watchdog reset with straps flipped
    boot_mode_i = 1'b0; tri_sel_ni = 1'b0; wdt_rst_i = 1'b1;
    cyc(1); chk("R2", sys_rst_no, 0); chk("R9", remap_o, 0); chk("R3", fetch_en_o, 0);
    cyc(2); wdt_rst_i = 1'b0;
    cyc(1); chk("R2", sys_rst_no, 0);
    cyc(1); chk("R2", sys_rst_no, 1);
    chk("R7", boot_mode_o, 1); chk("R7", tristate_o, 0);
    cyc(77); chk("R3", fetch_en_o, 0);
    cyc(1);  chk("R3", fetch_en_o, 1);
    // external reset: boot from CS0, tri-state mode
    rst_ni = 1'b0; #1;
    chk("R1", sys_rst_no, 0); chk("R3", fetch_en_o, 0);
    cyc(10); rst_ni = 1'b1;
    cyc(2); chk("R4", boot_mode_o, 0); chk("R6", tristate_o, 1); chk("R10", zero_sel_o, 0);
    cyc(5);
    // unstable strap: 0 for 10 samples, then 1 for the last 9
    rst_ni = 1'b0; boot_mode_i = 1'b0; tri_sel_ni = 1'b1;
    cyc(10); boot_mode_i = 1'b1; tri_sel_ni = 1'b0;
    cyc(8); rst_ni = 1'b1;
    cyc(2); chk("R5", boot_mode_o, 0); chk("R5", tristate_o, 1);
    cyc(3);
    // too-short reset
    rst_ni = 1'b0; boot_mode_i = 1'b1; tri_sel_ni = 1'b1;
    cyc(5); rst_ni = 1'b1;
    cyc(2); chk("R5", boot_mode_o, 0); chk("R5", tristate_o, 1);
    // full reset, remap write held across the reset release
    rst_ni = 1'b0; cyc(12);
    rst_ni = 1'b1; remap_wr_i = 1'b1; remap_wdata_i = 1'b1;
    cyc(2); chk("R8", remap_o, 0); chk("R4", boot_mode_o, 1);
    cyc(1); chk("R8", remap_o, 1);
    remap_wr_i = 1'b0; remap_wdata_i = 1'b0;
    cyc(3);
    // overlapping external and watchdog resets
    rst_ni = 1'b0; wdt_rst_i = 1'b1; boot_mode_i = 1'b0;
    cyc(12); rst_ni = 1'b1;
    cyc(3); chk("R2", sys_rst_no, 0); chk("R4", boot_mode_o, 0); chk("R9", remap_o, 0);
    wdt_rst_i = 1'b0;
    cyc(1); chk("R2", sys_rst_no, 0);
    cyc(1); chk("R2", sys_rst_no, 1);
    cyc(90); chk("R3", fetch_en_o, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule